// File: doc/BRIEF.md
# Full-Map Coherence Directory Controller

This block is the home-node directory for a distributed shared-memory machine with K processors. Each memory block it owns has a directory entry with one presence bit per processor and one dirty bit. The entry records which caches hold a copy and whether a single cache holds it modified. The controller accepts one read or write request at a time. Each request names the requesting processor and the block index. The controller then reads or updates the entry, sends coherence messages to caches, collects their acknowledgements, uses a synchronous memory port, and returns a single response to the requester.

A read of a clean block is served from memory. A read of a modified block first pulls the line back from its owner, which keeps a shared copy. The recalled data is then written to memory and forwarded. A write gains exclusive ownership. Every other sharer is invalidated by a single multicast message that carries a target vector, and the grant waits for all acknowledgements. If another cache holds the line modified, that owner is recalled and invalidated, and its data goes straight to the new owner. While a transaction is open, new requests are held off, with no queue and no retry path.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every entry is empty (no presence bits, clean), `req_ready` is 1 and `msg_valid` and `rsp_valid` are 0; a first read of any block sends no message.
- R2: A read of a clean block sends no message, reads memory (data returned one cycle after `mem_en`), responds with `rsp_excl`=0 and the memory word, and adds the requester to the sharers.
- R3: A read of a dirty block sends one message of kind 1 (recall, keep shared) with `msg_mask` equal to the presence vector. The recalled data from the acknowledgement is written to memory exactly once and returned to the requester. The entry becomes clean with both owner and requester marked.
- R4: A write to a clean block with other sharers sends one message of kind 0 (invalidate). Its `msg_mask` holds every sharer except the requester, all in one beat. The grant then carries the memory word.
- R5: A write to a block that is dirty in another cache sends kind 2 (recall and invalidate) to that owner. The grant carries the acknowledgement's data, and memory is not written.
- R6: The response is not issued until an acknowledgement has arrived from every target in `msg_mask`. An acknowledgement from a processor outside that set is ignored.
- R7: `req_ready` is 0 from the cycle after a request is accepted until the response cycle has passed.
- R8: A pending message keeps `msg_valid`, `msg_kind` and `msg_mask` unchanged until `msg_ready` is seen.
- R9: After a write grant only the requester's presence bit is set and the block is dirty. A later access from another processor therefore targets that processor alone.
- R10: The outstanding-acknowledgement count never exceeds K and always equals the number of targets still owed.
- R11: A write from a processor that is the only sharer, whether clean or owner, sends no message and is granted with the memory word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and accepting |
| req_write | input | 1 | 1 = write (ownership), 0 = read |
| req_src | input | $clog2(K) | Requesting processor |
| req_blk | input | $clog2(NBLK) | Block index |
| msg_valid | output | 1 | Coherence message present |
| msg_ready | input | 1 | Message accepted |
| msg_kind | output | 2 | 0 invalidate, 1 recall keep shared, 2 recall and invalidate |
| msg_mask | output | K | Target processors |
| msg_blk | output | $clog2(NBLK) | Block the message concerns |
| ack_valid | input | 1 | Acknowledgement strobe |
| ack_src | input | $clog2(K) | Acknowledging processor |
| ack_data | input | DW | Recalled line data |
| mem_en | output | 1 | Memory access |
| mem_we | output | 1 | Memory write |
| mem_addr | output | $clog2(NBLK) | Memory block index |
| mem_wdata | output | DW | Write-back data |
| mem_rdata | input | DW | Read data, valid the cycle after `mem_en` |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_dst | output | $clog2(K) | Processor the response is for |
| rsp_excl | output | 1 | 1 = exclusive write grant |
| rsp_data | output | DW | Line data |

## Verification
A corrupted presence vector or dirty bit shows up on the next request to that block. It appears as a wrong `msg_kind` or `msg_mask`, an unexpected or missing message, or stale response data. It also shows up as a missing or extra memory write, all within the same transaction. Random traffic over only four blocks revisits entries often, so a stale entry is caught within a few requests. A broken acknowledgement count shows up as a response that comes before the last acknowledgement, or as a transaction that never ends.

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl #(
  parameter int K    = 4,
  parameter int NBLK = 16,
  parameter int DW   = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [$clog2(K)-1:0]     req_src,
  input  logic [$clog2(NBLK)-1:0]  req_blk,
  output logic                     msg_valid,
  input  logic                     msg_ready,
  output logic [1:0]               msg_kind,
  output logic [K-1:0]             msg_mask,
  output logic [$clog2(NBLK)-1:0]  msg_blk,
  input  logic                     ack_valid,
  input  logic [$clog2(K)-1:0]     ack_src,
  input  logic [DW-1:0]            ack_data,
  output logic                     mem_en,
  output logic                     mem_we,
  output logic [$clog2(NBLK)-1:0]  mem_addr,
  output logic [DW-1:0]            mem_wdata,
  input  logic [DW-1:0]            mem_rdata,
  output logic                     rsp_valid,
  output logic [$clog2(K)-1:0]     rsp_dst,
  output logic                     rsp_excl,
  output logic [DW-1:0]            rsp_data
);
  localparam int PW = $clog2(K);
  localparam int BW = $clog2(NBLK);
  localparam int CW = $clog2(K) + 1;
  localparam logic [1:0] K_INV  = 2'd0;
  localparam logic [1:0] K_SHR  = 2'd1;
  localparam logic [1:0] K_RINV = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_SEND, S_WAIT, S_MRD, S_MWR, S_RSP} st_t;

  function automatic logic [CW-1:0] popc(input logic [K-1:0] v);
    popc = '0;
    for (int i = 0; i < K; i++) popc = popc + CW'(v[i]);
  endfunction

  logic [K-1:0]  pres [NBLK];
  logic [NBLK-1:0] dirt;

  st_t           st;
  logic          op_wr;
  logic [PW-1:0] src_q;
  logic [BW-1:0] blk_q;
  logic [1:0]    kind_q;
  logic [K-1:0]  mask_q;
  logic [K-1:0]  pend;
  logic [CW-1:0] cnt;
  logic [DW-1:0] cap;
  logic          from_mem;

  logic [K-1:0]  self_in, self_q, cur_p, wmask, need_mask;
  logic          cur_d, need_msg;
  logic [1:0]    need_kind;

  assign self_in = K'(1) << req_src;
  assign self_q  = K'(1) << src_q;
  assign cur_p   = pres[req_blk];
  assign cur_d   = dirt[req_blk];
  assign wmask   = cur_p & ~self_in;

  always_comb begin
    need_msg  = 1'b0;
    need_kind = K_INV;
    need_mask = '0;
    if (!req_write) begin
      if (cur_d) begin
        need_msg  = 1'b1;
        need_kind = K_SHR;
        need_mask = cur_p;
      end
    end else if (wmask != '0) begin
      need_msg  = 1'b1;
      need_kind = cur_d ? K_RINV : K_INV;
      need_mask = wmask;
    end
  end

  assign req_ready = (st == S_IDLE);
  assign msg_valid = (st == S_SEND);
  assign msg_kind  = kind_q;
  assign msg_mask  = mask_q;
  assign msg_blk   = blk_q;
  assign mem_en    = (st == S_MRD) || (st == S_MWR);
  assign mem_we    = (st == S_MWR);
  assign mem_addr  = blk_q;
  assign mem_wdata = cap;
  assign rsp_valid = (st == S_RSP);
  assign rsp_dst   = src_q;
  assign rsp_excl  = op_wr;
  assign rsp_data  = from_mem ? mem_rdata : cap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      op_wr    <= 1'b0;
      src_q    <= '0;
      blk_q    <= '0;
      kind_q   <= K_INV;
      mask_q   <= '0;
      pend     <= '0;
      cnt      <= '0;
      cap      <= '0;
      from_mem <= 1'b0;
      dirt     <= '0;
      for (int b = 0; b < NBLK; b++) pres[b] <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (req_valid) begin
          op_wr  <= req_write;
          src_q  <= req_src;
          blk_q  <= req_blk;
          kind_q <= need_kind;
          mask_q <= need_mask;
          if (need_msg) begin
            st <= S_SEND;
          end else begin
            from_mem <= 1'b1;
            st       <= S_MRD;
          end
        end
        S_SEND: if (msg_ready) begin
          pend <= mask_q;
          cnt  <= popc(mask_q);
          st   <= S_WAIT;
        end
        S_WAIT: begin
          if (cnt == '0) begin
            if (!op_wr) begin
              st <= S_MWR;
            end else if (kind_q == K_RINV) begin
              from_mem <= 1'b0;
              st       <= S_RSP;
            end else begin
              from_mem <= 1'b1;
              st       <= S_MRD;
            end
          end else if (ack_valid && pend[ack_src]) begin
            pend[ack_src] <= 1'b0;
            cnt           <= cnt - 1'b1;
            if (kind_q != K_INV) cap <= ack_data;
          end
        end
        S_MWR: begin
          from_mem <= 1'b0;
          st       <= S_RSP;
        end
        S_MRD: st <= S_RSP;
        S_RSP: begin
          if (op_wr) begin
            pres[blk_q] <= self_q;
            dirt[blk_q] <= 1'b1;
          end else begin
            pres[blk_q] <= pres[blk_q] | self_q;
            dirt[blk_q] <= 1'b0;
          end
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dir_home_ctrl_chk.sv
module dir_home_ctrl_chk #(
  parameter int K = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic                 msg_valid,
  input logic                 msg_ready,
  input logic [1:0]           msg_kind,
  input logic [K-1:0]         msg_mask,
  input logic                 rsp_valid,
  input logic                 mem_en,
  input logic [$clog2(K):0]   cnt,
  input logic [K-1:0]         pend
);
  p_accept_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);
  p_rsp_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
  p_msg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_mask) && $stable(msg_kind));
  p_msg_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_mask != '0) && (msg_kind != 2'd3));
  p_grant_acks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> cnt == '0);
  p_cnt_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= ($clog2(K)+1)'(K));
  p_cnt_track_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt == ($clog2(K)+1)'($countones(pend)));
  p_mem_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> !msg_valid && !rsp_valid);
endmodule

bind dir_home_ctrl dir_home_ctrl_chk #(.K(K)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_kind(msg_kind),
  .msg_mask(msg_mask), .rsp_valid(rsp_valid), .mem_en(mem_en),
  .cnt(cnt), .pend(pend)
);

// File: tb/dir_home_ctrl_tb.sv
module dir_home_ctrl_tb;
  localparam int K = 4, NBLK = 16, DW = 32;
  localparam int PW = $clog2(K), BW = $clog2(NBLK);

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, msg_ready = 0, ack_valid = 0;
  logic [PW-1:0] req_src = '0, ack_src = '0;
  logic [BW-1:0] req_blk = '0;
  logic [DW-1:0] ack_data = '0;
  logic req_ready, msg_valid, mem_en, mem_we, rsp_valid, rsp_excl;
  logic [1:0] msg_kind;
  logic [K-1:0] msg_mask;
  logic [BW-1:0] msg_blk, mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata, rsp_data;
  logic [PW-1:0] rsp_dst;

  always #10 clk = ~clk;

  dir_home_ctrl #(.K(K), .NBLK(NBLK), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_src(req_src), .req_blk(req_blk),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_kind(msg_kind),
    .msg_mask(msg_mask), .msg_blk(msg_blk), .ack_valid(ack_valid),
    .ack_src(ack_src), .ack_data(ack_data), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_dst(rsp_dst), .rsp_excl(rsp_excl),
    .rsp_data(rsp_data));

  logic [DW-1:0] mem [NBLK];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NBLK; i++) mem[i] <= 32'hA000_0000 + 32'(i) * 32'h0101;
    end else if (mem_en) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      mem_rdata <= mem[mem_addr];
    end
  end

  int checks = 0, errors = 0;
  logic [K-1:0]  mp [NBLK];
  logic          md [NBLK];
  logic [DW-1:0] emem [NBLK];
  logic [DW-1:0] cdat [NBLK];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [K-1:0] onehot(input int s);
    return K'(1) << s;
  endfunction

  task automatic run_req(input bit wr, input int src, input int blk, input bit stray, input string tag);
    logic [K-1:0] p, wm, emask;
    bit d, emsg, ewb, gotwb, gotrsp;
    logic [1:0] ekind;
    logic [DW-1:0] edata, wbdata;
    int dly, n;
    p = mp[blk]; d = md[blk]; wm = p & ~onehot(src);
    emsg = 0; ekind = 0; emask = '0;
    if (!wr) begin
      if (d) begin emsg = 1; ekind = 2'd1; emask = p; end
      edata = d ? cdat[blk] : emem[blk];
      ewb = d;
    end else begin
      if (wm != '0) begin emsg = 1; ekind = d ? 2'd2 : 2'd0; emask = wm; end
      edata = (d && wm != '0) ? cdat[blk] : emem[blk];
      ewb = 0;
    end
    @(negedge clk);
    chk(req_ready == 1'b1, {tag, " R7 ready when idle"}, 64'(req_ready), 64'd1);
    req_valid = 1; req_write = wr; req_src = PW'(src); req_blk = BW'(blk);
    @(negedge clk);
    req_valid = 0;
    gotwb = 0; gotrsp = 0; wbdata = '0;
    if (emsg) begin
      n = 0;
      while (!msg_valid && n < 20) begin
        if (rsp_valid) chk(0, {tag, " R6 response before message"}, 1, 0);
        @(negedge clk); n++;
      end
      chk(msg_valid == 1'b1, {tag, " R3/R4/R5 message expected"}, 64'(msg_valid), 64'd1);
      chk(msg_kind == ekind, {tag, " R3/R4/R5 message kind"}, 64'(msg_kind), 64'(ekind));
      chk(msg_mask == emask, {tag, " R4/R9 message mask"}, 64'(msg_mask), 64'(emask));
      chk(msg_blk == BW'(blk), {tag, " R4 message block"}, 64'(msg_blk), 64'(blk));
      chk(req_ready == 1'b0, {tag, " R7 busy while messaging"}, 64'(req_ready), 64'd0);
      dly = $urandom % 3;
      for (int i = 0; i < dly; i++) begin
        @(negedge clk);
        chk(msg_valid && msg_mask == emask && msg_kind == ekind, {tag, " R8 message held"},
            64'(msg_mask), 64'(emask));
      end
      msg_ready = 1;
      @(negedge clk);
      msg_ready = 0;
      if (stray) begin
        for (int s = 0; s < K; s++) if (!emask[s]) begin
          ack_valid = 1; ack_src = PW'(s); ack_data = 32'hDEAD_BEEF;
          @(negedge clk);
          ack_valid = 0;
          break;
        end
      end
      for (int s = 0; s < K; s++) if (emask[s]) begin
        chk(rsp_valid == 1'b0, {tag, " R6 no grant before all acks"}, 64'(rsp_valid), 64'd0);
        ack_valid = 1; ack_src = PW'(s); ack_data = cdat[blk];
        @(negedge clk);
        ack_valid = 0;
      end
    end else begin
      chk(msg_valid == 1'b0, {tag, " R1/R2/R11 no message"}, 64'(msg_valid), 64'd0);
    end
    n = 0;
    while (n < 20 && !gotrsp) begin
      if (msg_valid) chk(0, {tag, " R2/R11 unexpected message"}, 64'(msg_mask), 0);
      if (mem_en && mem_we) begin
        if (gotwb) chk(0, {tag, " R3 second write-back"}, 1, 0);
        gotwb = 1; wbdata = mem_wdata;
      end
      if (rsp_valid) begin
        gotrsp = 1;
        chk(rsp_dst == PW'(src), {tag, " R2 response destination"}, 64'(rsp_dst), 64'(src));
        chk(rsp_excl == wr, {tag, " R2/R4 response exclusive flag"}, 64'(rsp_excl), 64'(wr));
        chk(rsp_data == edata, {tag, " R2/R3/R4/R5 response data"}, 64'(rsp_data), 64'(edata));
        chk(req_ready == 1'b0, {tag, " R7 busy in response cycle"}, 64'(req_ready), 64'd0);
      end else begin
        @(negedge clk); n++;
      end
    end
    chk(gotrsp, {tag, " R6 response arrived"}, 64'(gotrsp), 64'd1);
    chk(gotwb == ewb, {tag, " R3/R5 memory write-back presence"}, 64'(gotwb), 64'(ewb));
    if (ewb && gotwb) chk(wbdata == cdat[blk], {tag, " R3 write-back data"}, 64'(wbdata), 64'(cdat[blk]));
    if (!wr) begin
      if (d) emem[blk] = cdat[blk];
      mp[blk] = p | onehot(src);
      md[blk] = 0;
    end else begin
      mp[blk] = onehot(src);
      md[blk] = 1;
      cdat[blk] = $urandom;
    end
  endtask

  initial begin
    int cyc;
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd12345));
    for (int b = 0; b < NBLK; b++) begin
      mp[b] = '0; md[b] = 0;
      emem[b] = 32'hA000_0000 + 32'(b) * 32'h0101;
      cdat[b] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", 64'(req_ready), 64'd1);
    chk(msg_valid == 1'b0, "R1 no message after reset", 64'(msg_valid), 64'd0);
    chk(rsp_valid == 1'b0, "R1 no response after reset", 64'(rsp_valid), 64'd0);
    run_req(0, 0, 5, 0, "R1 first read clean");
    run_req(0, 1, 5, 0, "R2 second sharer");
    run_req(0, 2, 5, 0, "R2 third sharer");
    run_req(1, 3, 5, 1, "R4 invalidate three sharers");
    run_req(0, 1, 5, 0, "R3 recall to shared");
    run_req(1, 1, 5, 0, "R9 owner kept shared copy");
    run_req(1, 2, 5, 1, "R5 recall and invalidate");
    run_req(1, 2, 5, 0, "R11 owner rewrite");
    run_req(1, 0, 9, 0, "R11 write to empty block");
    run_req(1, 0, 9, 0, "R11 sole owner again");
    for (int t = 0; t < 400; t++)
      run_req(($urandom % 3) == 0, $urandom % K, $urandom % 4, ($urandom % 4) == 0, "R10 random");
    repeat (2) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule